// File: doc/BRIEF.md
# Self-Starting Five-Code Sequence Counter

This block is a 3-bit synchronous counter held in three D flip-flops. Instead of counting in binary it walks a fixed loop of five codes, and the remaining three codes are treated as unused. The next-state logic is written as three minimized equations. Those equations also send every unused code back into the loop, so the counter recovers on its own from any power-on value or from a flipped state bit. It never sits in a loop made only of unused codes.

The counter moves one step on each rising clock edge while its enable is high, and holds while the enable is low. A synchronous active-high reset puts it at the loop's starting code. A combinational flag goes high whenever the state holds one of the unused codes, so surrounding logic can tell when a recovery is in progress.

Top module: `skip_seq_counter`

## Requirements
- R1: When `rst` is high at a rising clock edge, the state becomes 000 at that edge, whatever the enable input or the current state.
- R2: When `rst` is low and `countEn` is low at a rising edge, the state keeps its value. This applies to unused codes as well as to loop codes.
- R3: With `countEn` high, the loop codes step in this order: 000, 010, 011, 101, 110, then back to 000. Each code is written as C B A, where C is `stateOut[2]`, B is `stateOut[1]` and A is `stateOut[0]`.
- R4: With `countEn` high, the unused code 001 steps to 110.
- R5: With `countEn` high, the unused code 100 steps to 010.
- R6: With `countEn` high, the unused code 111 steps to 100.
- R7: `unusedFlag` is high exactly while the state is 001, 100 or 111. It follows the state combinationally.
- R8: From any of the eight codes, at most two enabled clocks bring the state onto a loop code. No unused code leads back to an unused code more than once.
- R9: For every present state, the next state with `countEn` high satisfies C+ = A, B+ = (not B) or ((not A) and (not C)), and A+ = B and (not C).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset to code 000 |
| countEn | input | 1 | Advance one step per clock when high, hold when low |
| stateOut | output | 3 | Present code, bit 2 = C, bit 1 = B, bit 0 = A |
| unusedFlag | output | 1 | High while the present code is one of the three unused codes |

## Verification
The bench puts each of the eight codes directly into the state register, as a bit upset would. It then checks the flag and compares the next state against the three equations. A design that used don't-care freedom carelessly could send 111 back to itself or to another unused code, and the following step would then miss the loop. The bench also holds an unused code with the enable low, because a design that recovers even when disabled would leave 111 early. It applies reset in the middle of the loop to catch a reset that waits for the enable or for a particular loop position.

// File: rtl/skip_seq_pkg.sv
package skip_seq_pkg;

  localparam int STATE_W = 3;

  typedef logic [STATE_W-1:0] code_t;

  localparam code_t RESET_CODE = 3'b000;
  localparam code_t UNUSED_LO  = 3'b001;
  localparam code_t UNUSED_MID = 3'b100;
  localparam code_t UNUSED_HI  = 3'b111;

  // bit positions of the named state bits
  localparam int BIT_C = 2;
  localparam int BIT_B = 1;
  localparam int BIT_A = 0;

  typedef struct packed {
    logic clear;
    logic advance;
  } ctrl_strobe_t;

endpackage

// File: rtl/skip_seq_control.sv
module skip_seq_control
  import skip_seq_pkg::*;
(
  input  logic         rst,
  input  logic         countEn,
  output ctrl_strobe_t strobes
);

  // reset wins over enable
  always_comb begin
    strobes.clear   = rst;
    strobes.advance = countEn & ~rst;
  end

endmodule

// File: rtl/skip_seq_datapath.sv
module skip_seq_datapath
  import skip_seq_pkg::*;
(
  input  logic         clk,
  input  ctrl_strobe_t strobes,
  output code_t        stateOut,
  output logic         unusedOut
);

  code_t stateQ;
  code_t stateNext;
  code_t eqNext;
  logic  isUnused;

  // minimized next-state equations; unused codes fall out of the same logic
  always_comb begin
    eqNext[BIT_C] = stateQ[BIT_A];
    eqNext[BIT_B] = ~stateQ[BIT_B] | (~stateQ[BIT_A] & ~stateQ[BIT_C]);
    eqNext[BIT_A] = stateQ[BIT_B] & ~stateQ[BIT_C];
  end

  always_comb begin
    if (strobes.clear)        stateNext = RESET_CODE;
    else if (strobes.advance) stateNext = eqNext;
    else                      stateNext = stateQ;
  end

  always_ff @(posedge clk) begin
    stateQ <= stateNext;
  end

  always_comb begin
    unique case (stateQ)
      UNUSED_LO, UNUSED_MID, UNUSED_HI: isUnused = 1'b1;
      default:                          isUnused = 1'b0;
    endcase
  end

  assign stateOut  = stateQ;
  assign unusedOut = isUnused;

  // counts enabled steps taken while sitting on unused codes
  logic [1:0] unusedRun;
  always_ff @(posedge clk) begin
    if (strobes.clear || !isUnused) unusedRun <= 2'd0;
    else if (strobes.advance && unusedRun != 2'd3) unusedRun <= unusedRun + 2'd1;
  end

  p_reset_r1: assert property (@(posedge clk)
    strobes.clear |=> stateQ == RESET_CODE);

  p_hold_r2: assert property (@(posedge clk) disable iff (strobes.clear)
    (!strobes.clear && !strobes.advance) |=> $stable(stateQ));

  p_exit_lo_r4: assert property (@(posedge clk) disable iff (strobes.clear)
    (strobes.advance && stateQ == UNUSED_LO) |=> stateQ == 3'b110);

  p_exit_mid_r5: assert property (@(posedge clk) disable iff (strobes.clear)
    (strobes.advance && stateQ == UNUSED_MID) |=> stateQ == 3'b010);

  p_exit_hi_r6: assert property (@(posedge clk) disable iff (strobes.clear)
    (strobes.advance && stateQ == UNUSED_HI) |=> stateQ == UNUSED_MID);

  p_bounded_recovery_r8: assert property (@(posedge clk) disable iff (strobes.clear)
    isUnused |-> unusedRun < 2'd2);

endmodule

// File: rtl/skip_seq_counter.sv
module skip_seq_counter
  import skip_seq_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                countEn,
  output logic [STATE_W-1:0]  stateOut,
  output logic                unusedFlag
);

  ctrl_strobe_t strobes;
  code_t        stateW;
  logic         unusedW;

  skip_seq_control u_control (
    .rst     (rst),
    .countEn (countEn),
    .strobes (strobes)
  );

  skip_seq_datapath u_datapath (
    .clk       (clk),
    .strobes   (strobes),
    .stateOut  (stateW),
    .unusedOut (unusedW)
  );

  assign stateOut   = stateW;
  assign unusedFlag = unusedW;

endmodule

// File: tb/test_skip_seq_counter.sv
module test_skip_seq_counter;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       countEn = 1'b0;
  logic [2:0] stateOut;
  logic       unusedFlag;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  typedef struct {
    logic [2:0] expState;
    logic       expFlag;
    string      tag;
  } item_t;

  item_t expQ[$];
  logic [2:0] model = 3'b000;

  skip_seq_counter i_skip_seq_counter (
    .clk        (clk),
    .rst        (rst),
    .countEn    (countEn),
    .stateOut   (stateOut),
    .unusedFlag (unusedFlag)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // loop order and unused exits from R3..R6
  function automatic logic [2:0] tableNext(logic [2:0] s);
    case (s)
      3'b000: return 3'b010;
      3'b010: return 3'b011;
      3'b011: return 3'b101;
      3'b101: return 3'b110;
      3'b110: return 3'b000;
      3'b001: return 3'b110;
      3'b100: return 3'b010;
      default: return 3'b100;
    endcase
  endfunction

  // equations from R9
  function automatic logic [2:0] eqnNext(logic [2:0] s);
    logic c, b, a;
    {c, b, a} = s;
    return {a, ~b | (~a & ~c), b & ~c};
  endfunction

  // unused codes from R7
  function automatic logic flagOf(logic [2:0] s);
    return (s == 3'b001) || (s == 3'b100) || (s == 3'b111);
  endfunction

  task automatic check(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0b expected=%0b", tag, what, act, exp);
    end
  endtask

  // driver: sets inputs after a falling edge and queues the expected result
  task automatic drive(bit r, bit e, bit useEq, string tag);
    item_t it;
    rst = r;
    countEn = e;
    if (r)      model = 3'b000;
    else if (e) model = useEq ? eqnNext(model) : tableNext(model);
    it.expState = model;
    it.expFlag  = flagOf(model);
    it.tag      = tag;
    expQ.push_back(it);
    @(negedge clk);
  endtask

  // monitor: compares just after each rising edge
  always @(posedge clk) begin
    #2;
    if (expQ.size() > 0) begin
      item_t it;
      it = expQ.pop_front();
      check(stateOut == it.expState, it.tag, "state", stateOut, it.expState);
      check(unusedFlag == it.expFlag, it.tag, "flag", unusedFlag, it.expFlag);
    end
  end

  // bit-upset model: place a code straight into the state register
  task automatic inject(logic [2:0] code);
    force i_skip_seq_counter.u_datapath.stateQ = code;
    #1;
    release i_skip_seq_counter.u_datapath.stateQ;
    model = code;
    #1;
    check(stateOut == code, "R7", "injected state", stateOut, code);
    check(unusedFlag == flagOf(code), "R7", "flag on injected code", unusedFlag, flagOf(code));
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    // R1: reset state
    drive(1, 0, 0, "R1");
    drive(1, 1, 0, "R1");
    // R3: full loop twice
    for (int i = 0; i < 10; i++) drive(0, 1, 0, "R3");
    // R2: hold on loop codes
    drive(0, 1, 0, "R3");
    for (int i = 0; i < 3; i++) drive(0, 0, 0, "R2");
    // mixed enable pattern
    for (int i = 0; i < 8; i++) drive(0, (i % 3) != 0, 0, "R3");
    // R1: reset mid-loop
    drive(1, 1, 0, "R1");
    drive(0, 1, 0, "R3");
    drive(0, 1, 0, "R3");
    drive(1, 0, 0, "R1");

    // all eight start codes: R9 equations, then R8 two-clock recovery
    for (int c = 0; c < 8; c++) begin
      drive(1, 1, 0, "R1");
      drive(0, 1, 0, "R3");
      inject(3'(c));
      drive(0, 1, 1, "R9");
      check(eqnNext(3'(c)) == tableNext(3'(c)), "R9", "table vs eq", eqnNext(3'(c)), tableNext(3'(c)));
      if (c == 1) drive(0, 1, 0, "R4");
      else if (c == 4) drive(0, 1, 0, "R5");
      else if (c == 7) drive(0, 1, 0, "R6");
      else drive(0, 1, 0, "R8");
      #3;
      check(!flagOf(stateOut), "R8", "on loop after two steps", stateOut, tableNext(tableNext(3'(c))));
    end

    // R6 and R2: unused code held with enable low, then exits
    drive(1, 1, 0, "R1");
    drive(0, 1, 0, "R3");
    inject(3'b111);
    drive(0, 0, 0, "R2");
    drive(0, 0, 0, "R2");
    drive(0, 1, 0, "R6");
    drive(0, 1, 0, "R5");
    // R1: reset overrides an unused code
    drive(0, 1, 0, "R3");
    inject(3'b001);
    drive(1, 1, 0, "R1");

    @(negedge clk);
    @(negedge clk);
    check(expQ.size() == 0, "R3", "scoreboard drained", expQ.size(), 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule